// File: doc/BRIEF.md
# Compare/Capture Timer-Counter

This block is a memory-mapped timer/counter with four compare/capture channels. A simple 32-bit register bus carries word addresses, a write strobe, write data and combinational read data. In timer mode the counter advances on prescaled ticks of the system clock. In counter mode it advances once for each count-task write. Each channel holds a compare value. A channel raises an event flag when the counter steps onto that value. The channel can also clear or halt the counter at that point, and it can capture the running count on request. A single level interrupt combines the event flags through an enable mask.

Writes take effect on the clock edge at which `bus_we` is high. The bus never stalls, so it has no valid/ready pairing; every pin is plain control or status. Tasks are addresses that act when the value 1 is written to them. Configuration registers read back their stored value. The counter itself is not readable: software captures it into a channel and reads that channel.

Word addresses: 0x00 start, 0x01 stop, 0x02 count, 0x03 clear, 0x04 shutdown, 0x08+i capture channel i, 0x10+i event flag i, 0x20 shortcuts, 0x21 enable-set, 0x22 enable-clear, 0x23 mode, 0x24 width select, 0x25 prescaler, 0x28+i compare value i.

Top module: `cc_timer`

## Requirements
- R1: The width select (0x24, 2 bits) sets the counter width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The counter steps from 2^width-1 back to 0.
- R2: In timer mode while running, the counter advances once every 2^P clocks, where P is the prescaler (0x25, 4 bits). The first advance lands 2^P clocks after the start write. A written P above 9 is stored and read back as 9.
- R3: When the counter advances onto the compare value of channel i, event flag i (bit 0 of 0x10+i) becomes 1. It stays 1 until 0 is written to that address; a nonzero write leaves it unchanged.
- R4: Shortcut bit i (0x20 bits 0..3) makes a compare hit on channel i load 0 into the counter instead of the compare value. Shortcut bit 8+i halts counting on that hit. Other shortcut bits read as 0.
- R5: `irq` is high exactly when some channel i has both its event flag and enable bit 16+i set. Writing 0x21 sets the written enable bits, and writing 0x22 clears them. Both addresses read the enable register, and only bits 16..19 are stored.
- R6: Mode (0x23 bit 0) is 0 for timer and 1 for counter. Start acts only in timer mode, and count acts only in counter mode. Stop and shutdown both halt counting.
- R7: Capture i copies the current counter value into compare value i. A write to compare value i is stored modulo 2^width.
- R8: Clear loads 0 into the counter and restarts the tick phase. The running state does not change.
- R9: A task write with any value other than 1 has no effect.
- R10: After reset, the counter, running state, event flags, compare values, shortcuts, enables, mode, width select and prescaler are all 0.
- R11: While halted, and with no bus write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word address |
| bus_we | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps the prescaler over the capture delays that land just before and just after each tick boundary. A divider that is off by one shows a count one step high or low. In counter mode the bench counts across the full 8-bit and 16-bit ranges, so a wrong width decode wraps at the wrong point or never returns to zero. The bench also checks that a clear shortcut restarts the counter from zero rather than leaving it on the compare value, and that a halt shortcut freezes the counter at the compare value. Finally, it writes tasks with values other than 1 and issues start in counter mode and count in timer mode. A loose decode of any of these would move the captured count.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned AW = 6;

  localparam logic [AW-1:0] A_START    = 6'h00;
  localparam logic [AW-1:0] A_STOP     = 6'h01;
  localparam logic [AW-1:0] A_COUNT    = 6'h02;
  localparam logic [AW-1:0] A_CLEAR    = 6'h03;
  localparam logic [AW-1:0] A_SHUTDOWN = 6'h04;
  localparam logic [AW-1:0] A_CAP0     = 6'h08;
  localparam logic [AW-1:0] A_EVT0     = 6'h10;
  localparam logic [AW-1:0] A_SHORTS   = 6'h20;
  localparam logic [AW-1:0] A_IEN_SET  = 6'h21;
  localparam logic [AW-1:0] A_IEN_CLR  = 6'h22;
  localparam logic [AW-1:0] A_MODE     = 6'h23;
  localparam logic [AW-1:0] A_WIDTH    = 6'h24;
  localparam logic [AW-1:0] A_PRESC    = 6'h25;
  localparam logic [AW-1:0] A_CMP0     = 6'h28;

  localparam int unsigned STOP_SH_OFS = 8;
  localparam int unsigned IEN_OFS     = 16;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNTER = 1'b1} cct_mode_e;

  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_FFFF;
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input int unsigned n, input int unsigned ofs);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < n; k++) m[ofs+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
  parameter int unsigned MAX_PS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [3:0] ps,
  output logic       tick
);
  localparam int unsigned PW = (MAX_PS < 1) ? 1 : MAX_PS;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  always_comb begin
    limit = ~({PW{1'b1}} << ps);
    tick  = run && (pre_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pre_q <= '0;
    else if (!run || restart || tick) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

  // R2: with a nonzero prescaler two ticks never fall on adjacent cycles
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ps != 4'd0) |=> (!tick || ps == 4'd0));
endmodule

// File: rtl/cct_channel.sv
module cct_channel import cct_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] cnt_q,
  input  logic [WORD_W-1:0] cnt_nxt,
  input  logic              adv,
  input  logic              cmp_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cap,
  input  logic              evt_clr,
  output logic [WORD_W-1:0] cmp_q,
  output logic              evt_q,
  output logic              hit
);
  always_comb hit = adv && (cnt_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_wr) cmp_q <= wdata & mask;
    else if (cap)    cmp_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (hit)     evt_q <= 1'b1;
    else if (evt_clr) evt_q <= 1'b0;
  end

  p_evt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> evt_q);
  p_cmp_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> ((cmp_q & ~$past(mask)) == '0));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !cmp_wr) |=> (cmp_q == $past(cnt_q)));
endmodule

// File: rtl/cct_cfg.sv
module cct_cfg import cct_pkg::*; #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned MAX_PS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output cct_mode_e         mode_q,
  output logic [1:0]        width_q,
  output logic [3:0]        ps_q,
  output logic [WORD_W-1:0] shorts_q,
  output logic [WORD_W-1:0] ien_q,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [WORD_W-1:0] SH_MASK  = lane_mask(NCH, 0) | lane_mask(NCH, STOP_SH_OFS);
  localparam logic [WORD_W-1:0] IEN_MASK = lane_mask(NCH, IEN_OFS);
  localparam logic [3:0]        PS_TOP   = 4'(MAX_PS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_TIMER;
      width_q  <= 2'd0;
      ps_q     <= 4'd0;
      shorts_q <= '0;
      ien_q    <= '0;
    end else if (we) begin
      case (addr)
        A_MODE:    mode_q   <= cct_mode_e'(wdata[0]);
        A_WIDTH:   width_q  <= wdata[1:0];
        A_PRESC:   ps_q     <= (wdata[3:0] > PS_TOP) ? PS_TOP : wdata[3:0];
        A_SHORTS:  shorts_q <= wdata & SH_MASK;
        A_IEN_SET: ien_q    <= ien_q | (wdata & IEN_MASK);
        A_IEN_CLR: ien_q    <= ien_q & ~(wdata & IEN_MASK);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:               rdata = {{(WORD_W-1){1'b0}}, mode_q};
      A_WIDTH:              rdata = {{(WORD_W-2){1'b0}}, width_q};
      A_PRESC:              rdata = {{(WORD_W-4){1'b0}}, ps_q};
      A_SHORTS:             rdata = shorts_q;
      A_IEN_SET, A_IEN_CLR: rdata = ien_q;
      default: ;
    endcase
  end

  p_presc_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ps_q <= PS_TOP);
  p_ien_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_IEN_SET) |=> ((ien_q & $past(wdata) & IEN_MASK) == ($past(wdata) & IEN_MASK)));
endmodule

// File: rtl/cc_timer.sv
module cc_timer import cct_pkg::*; #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned MAX_PS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  cct_mode_e         mode_q;
  logic [1:0]        width_q;
  logic [3:0]        ps_q;
  logic [WORD_W-1:0] shorts_q, ien_q, cfg_rdata, ch_rdata;
  logic [WORD_W-1:0] mask, cnt_q, cnt_nxt;
  logic              run_q, tick, adv, timer_mode, trig;
  logic              t_start, t_stop, t_count, t_clear, t_shut;
  logic              clr_hit, stop_hit;
  logic [NCH-1:0]    hit, evt, cap, evt_clr, cmp_wr;
  logic [WORD_W-1:0] cmp_v [NCH];

  cct_cfg #(.NCH(NCH), .MAX_PS(MAX_PS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .width_q(width_q), .ps_q(ps_q), .shorts_q(shorts_q),
    .ien_q(ien_q), .rdata(cfg_rdata)
  );

  always_comb begin
    trig       = bus_we && (bus_wdata == 32'd1);
    t_start    = trig && (bus_addr == A_START);
    t_stop     = trig && (bus_addr == A_STOP);
    t_count    = trig && (bus_addr == A_COUNT);
    t_clear    = trig && (bus_addr == A_CLEAR);
    t_shut     = trig && (bus_addr == A_SHUTDOWN);
    timer_mode = (mode_q == MODE_TIMER);
    mask       = width_mask(width_q);
    cnt_nxt    = (cnt_q + 32'd1) & mask;
    adv        = !t_clear && (tick || (t_count && !timer_mode));
    clr_hit    = |(hit & shorts_q[NCH-1:0]);
    stop_hit   = |(hit & shorts_q[STOP_SH_OFS +: NCH]);
    irq        = |(evt & ien_q[IEN_OFS +: NCH]);
  end

  cct_tick_gen #(.MAX_PS(MAX_PS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_q && timer_mode), .restart(t_clear),
    .ps(ps_q), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      cap[g]     = trig && (bus_addr == A_CAP0 + AW'(g));
      evt_clr[g] = bus_we && (bus_wdata == '0) && (bus_addr == A_EVT0 + AW'(g));
      cmp_wr[g]  = bus_we && (bus_addr == A_CMP0 + AW'(g));
    end
    cct_channel u_ch (
      .clk(clk), .rst_n(rst_n), .mask(mask), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
      .adv(adv), .cmp_wr(cmp_wr[g]), .wdata(bus_wdata), .cap(cap[g]),
      .evt_clr(evt_clr[g]), .cmp_q(cmp_v[g]), .evt_q(evt[g]), .hit(hit[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (t_clear) cnt_q <= '0;
    else if (adv)     cnt_q <= clr_hit ? '0 : cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_q <= 1'b0;
    else if (t_stop || t_shut)        run_q <= 1'b0;
    else if (stop_hit)                run_q <= 1'b0;
    else if (t_start && timer_mode)   run_q <= 1'b1;
  end

  always_comb begin
    ch_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == A_EVT0 + AW'(i)) ch_rdata = {{(WORD_W-1){1'b0}}, evt[i]};
      if (bus_addr == A_CMP0 + AW'(i)) ch_rdata = cmp_v[i];
    end
    bus_rdata = cfg_rdata | ch_rdata;
  end

  p_start_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_start && mode_q == MODE_COUNTER && !run_q) |=> !run_q);
  p_stop_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !run_q);
  p_clear_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt_q == '0));
  p_clear_task_r8: assert property (@(posedge clk) disable iff (!rst_n)
    t_clear |=> ((cnt_q == '0) && (run_q == $past(run_q))));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !bus_we) |=> $stable(cnt_q));
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_COUNT && bus_wdata != 32'd1 && !run_q) |=> $stable(cnt_q));
endmodule

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;
  import cct_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic              we = 1'b0;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic              irq;
  int checks = 0;
  int errors = 0;
  int js[6] = '{0, 1, 3, 7, 8, 17};

  cc_timer i_cc_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic wr(input logic [AW-1:0] a, input logic [WORD_W-1:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic chk(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cap(input int ch, output logic [WORD_W-1:0] v);
    wr(A_CAP0 + AW'(ch), 32'd1);
    rd(A_CMP0 + AW'(ch), v);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk); #1 chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] v, a, b, m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(A_SHORTS, v); chk("R10 shorts", v, 0);
    rd(A_IEN_SET, v); chk("R10 enable", v, 0);
    rd(A_MODE, v);   chk("R10 mode", v, 0);
    rd(A_WIDTH, v);  chk("R10 width", v, 0);
    rd(A_PRESC, v);  chk("R10 prescaler", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(A_CMP0 + AW'(i), v); chk("R10 compare", v, 0);
      rd(A_EVT0 + AW'(i), v); chk("R10 event", v, 0);
    end
    chk_irq("R10 irq", 1'b0);
    cap(0, v); chk("R10 counter", v, 0);

    // R5 enable register set/clear and masking
    wr(A_IEN_SET, 32'hFFFF_FFFF); rd(A_IEN_CLR, v); chk("R5 set mask", v, 32'h000F_0000);
    wr(A_IEN_CLR, 32'h0005_0000); rd(A_IEN_SET, v); chk("R5 clear", v, 32'h000A_0000);
    wr(A_IEN_CLR, 32'hFFFF_FFFF); rd(A_IEN_SET, v); chk("R5 clear all", v, 0);
    // R4 shortcut mask
    wr(A_SHORTS, 32'hFFFF_FFFF); rd(A_SHORTS, v); chk("R4 shorts mask", v, 32'h0000_0F0F);
    wr(A_SHORTS, 32'd0);
    // R2 prescaler saturation
    wr(A_PRESC, 32'd12); rd(A_PRESC, v); chk("R2 sat 12", v, 9);
    wr(A_PRESC, 32'd15); rd(A_PRESC, v); chk("R2 sat 15", v, 9);
    wr(A_PRESC, 32'd7);  rd(A_PRESC, v); chk("R2 keep 7", v, 7);
    wr(A_PRESC, 32'd0);
    // R7 compare write reduced modulo width, per width select
    for (int w = 0; w < 4; w++) begin
      m = (w == 0) ? 32'hFFFF : (w == 1) ? 32'hFF : (w == 2) ? 32'hFF_FFFF : 32'hFFFF_FFFF;
      wr(A_WIDTH, WORD_W'(w));
      rd(A_WIDTH, v); chk("R1 width readback", v, WORD_W'(w));
      wr(A_CMP0 + AW'(2), 32'hFFFF_FFFF);
      rd(A_CMP0 + AW'(2), v); chk("R7 compare modulo", v, m);
    end

    // R1 and R6 counter mode wrap
    wr(A_MODE, 32'd1); wr(A_WIDTH, 32'd1); wr(A_CLEAR, 32'd1);
    for (int k = 0; k < 300; k++) wr(A_COUNT, 32'd1);
    cap(0, v); chk("R1 8-bit 300 counts", v, 300 % 256);
    wr(A_WIDTH, 32'd2); wr(A_CLEAR, 32'd1);
    for (int k = 0; k < 300; k++) wr(A_COUNT, 32'd1);
    cap(0, v); chk("R1 24-bit no early wrap", v, 300);
    wr(A_WIDTH, 32'd0); wr(A_CLEAR, 32'd1);
    for (int k = 0; k < 65535; k++) wr(A_COUNT, 32'd1);
    cap(0, v); chk("R1 16-bit top", v, 32'hFFFF);
    wr(A_COUNT, 32'd1);
    cap(0, v); chk("R1 16-bit wrap", v, 0);

    // R3 compare event, R5 interrupt
    for (int i = 0; i < 4; i++) wr(A_EVT0 + AW'(i), 32'd0);
    wr(A_CMP0, 32'd5); wr(A_CLEAR, 32'd1);
    for (int k = 0; k < 4; k++) wr(A_COUNT, 32'd1);
    rd(A_EVT0, v); chk("R3 before match", v, 0);
    wr(A_COUNT, 32'd1);
    rd(A_EVT0, v); chk("R3 on match", v, 1);
    wr(A_IEN_SET, 32'h0002_0000); chk_irq("R5 other enable", 1'b0);
    wr(A_IEN_SET, 32'h0001_0000); chk_irq("R5 enabled", 1'b1);
    wr(A_EVT0, 32'd1); rd(A_EVT0, v); chk("R3 nonzero write ignored", v, 1);
    wr(A_EVT0, 32'd0); rd(A_EVT0, v); chk("R3 zero clears", v, 0);
    chk_irq("R5 irq drops", 1'b0);
    wr(A_IEN_CLR, 32'h0003_0000);

    // R4 clear shortcut
    wr(A_SHORTS, 32'h2); wr(A_CMP0 + AW'(1), 32'd3); wr(A_CLEAR, 32'd1);
    for (int k = 0; k < 3; k++) wr(A_COUNT, 32'd1);
    cap(3, v); chk("R4 clear shortcut", v, 0);
    rd(A_EVT0 + AW'(1), v); chk("R4 event on clear hit", v, 1);
    wr(A_COUNT, 32'd1); wr(A_COUNT, 32'd1);
    cap(3, v); chk("R4 after clear", v, 2);
    wr(A_SHORTS, 32'd0);

    // R9 task values other than 1
    wr(A_CLEAR, 32'd1); wr(A_COUNT, 32'd2);
    cap(0, v); chk("R9 count value 2", v, 0);
    wr(A_COUNT, 32'd1); wr(A_CLEAR, 32'd3);
    cap(0, v); chk("R9 clear value 3", v, 1);

    // R6 start ignored in counter mode, count ignored in timer mode
    wr(A_START, 32'd1); wr(A_MODE, 32'd0);
    repeat (10) @(negedge clk);
    cap(0, v); chk("R6 start in counter mode", v, 1);
    wr(A_COUNT, 32'd1);
    cap(0, v); chk("R6 count in timer mode", v, 1);
    wr(A_START, 32'd2);
    repeat (5) @(negedge clk);
    cap(0, v); chk("R9 start value 2", v, 1);

    // R2 timer mode tick sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 6; k++) begin
        wr(A_PRESC, WORD_W'(p)); wr(A_CLEAR, 32'd1); wr(A_START, 32'd1);
        repeat (js[k]) @(negedge clk);
        cap(0, v); wr(A_STOP, 32'd1);
        chk("R2 tick sweep", v, WORD_W'(js[k] >> p));
      end
    end
    wr(A_PRESC, 32'd12); wr(A_CLEAR, 32'd1); wr(A_START, 32'd1);
    repeat (1030) @(negedge clk);
    cap(0, v); wr(A_STOP, 32'd1);
    chk("R2 saturated prescaler", v, 2);
    wr(A_PRESC, 32'd0);

    // R8 clear while running
    wr(A_CLEAR, 32'd1); wr(A_START, 32'd1);
    repeat (5) @(negedge clk);
    wr(A_CLEAR, 32'd1);
    repeat (6) @(negedge clk);
    cap(0, v); chk("R8 clear keeps running", v, 6);
    wr(A_STOP, 32'd1);

    // R6 shutdown halts, R11 counter holds
    wr(A_CLEAR, 32'd1); wr(A_START, 32'd1);
    repeat (5) @(negedge clk);
    wr(A_SHUTDOWN, 32'd1);
    cap(0, a); chk("R6 shutdown value", a, 6);
    repeat (10) @(negedge clk);
    cap(0, b); chk("R11 hold while halted", b, a);

    // R4 stop shortcut
    for (int i = 0; i < 4; i++) wr(A_EVT0 + AW'(i), 32'd0);
    wr(A_SHORTS, 32'h400); wr(A_CMP0 + AW'(2), 32'd4);
    wr(A_CLEAR, 32'd1); wr(A_START, 32'd1);
    repeat (20) @(negedge clk);
    cap(3, v); chk("R4 stop shortcut", v, 4);
    rd(A_EVT0 + AW'(2), v); chk("R4 stop event", v, 1);
    wr(A_SHORTS, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule